// File: doc/BRIEF.md
# Ping-Pong Transmit Packet Buffer

This block holds outgoing packets for a single bulk IN endpoint of a serial-bus function controller. It has two packet stores used alternately. The processor loads bytes into whichever store it currently owns. It then issues a commit pulse, which hands that store to the host-facing side, and the host side reads it out byte by byte. An end-of-packet pulse from the host side returns the store to the processor side. A store that has been committed is always read in full before the other one. Stores are handed to the host side in the same order the processor committed them.

A readable status byte carries one pending-data bit, at bit 0. This bit rises only on a commit; plain writes never set it. It stays high while either store still holds a committed packet. A write-one clear pulse empties both stores, whether their contents were committed or not. The clear is mirrored by a flag that reads back as 1 for exactly one cycle. The clear leaves the packet-sent interrupt flag untouched.

Top module: `ep_tx_pingpong`

## Requirements
- R1: After reset, dataStatus, statusReg, bufFull, hostPktReady, hostDataValid, clrBit and pktSentFlag are all 0, and cpuWrReady is 1.
- R2: Byte writes alone never set dataStatus. An accepted cpuCommit sets dataStatus from the next cycle on. statusReg carries dataStatus in bit 0, and bits 7:1 always read 0.
- R3: A commit with no bytes loaded is a valid zero-length packet: dataStatus and hostPktReady rise, and hostPktLen reads 0.
- R4: When both stores hold committed packets, bufFull is 1, cpuWrReady is 0, and any write or commit is ignored.
- R5: The host side receives packets in commit order, with bytes in write order, and hostPktLen equals the number of bytes accepted for that packet.
- R6: hostEop frees the store being read. dataStatus stays 1 while the other store still holds a committed packet, and falls to 0 only when both stores are empty.
- R7: Each store accepts at most DEPTH bytes (64 by default). Once it is full, cpuWrReady is 0 and further writes are dropped.
- R8: A clrWrite pulse empties both stores, including committed and uncommitted data. Afterwards dataStatus, bufFull and hostPktReady are 0, and the next packet starts from its first byte.
- R9: clrBit reads 1 in the single cycle after a clrWrite pulse and 0 after that.
- R10: pktSentFlag is set when hostEop frees a committed packet and cleared by intAck. A clear never changes it.
- R11: If clrWrite and cpuCommit arrive in the same cycle, the clear takes precedence and dataStatus is 0 afterwards.
- R12: When both stores are committed and the host frees one, the processor side moves to the freed store and cpuWrReady returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | Processor byte write strobe |
| cpuWrData | input | DATA_W | Processor write byte |
| cpuCommit | input | 1 | Packet-enable pulse handing the current store to the host side |
| clrWrite | input | 1 | Write-one pulse that flushes both stores |
| hostRdEn | input | 1 | Host-side read strobe, advances the read pointer |
| hostEop | input | 1 | Host-side end-of-packet, frees the store being read |
| intAck | input | 1 | Clears the packet-sent flag |
| cpuWrReady | output | 1 | Current processor store can take a byte |
| bufFull | output | 1 | Both stores hold committed packets |
| hostPktReady | output | 1 | A committed packet is available to the host side |
| hostDataValid | output | 1 | hostRdData holds an unread byte |
| hostRdData | output | DATA_W | Byte at the host read pointer |
| hostPktLen | output | CNT_W | Byte count of the packet offered to the host side |
| dataStatus | output | 1 | Committed data still waiting |
| statusReg | output | 8 | Status byte, dataStatus in bit 0 |
| clrBit | output | 1 | Self-clearing read-back of the clear command |
| pktSentFlag | output | 1 | Packet-sent interrupt flag |

## Verification
The hardest state to reach is both stores committed while the host side is still busy with the older one. In that state the processor side must first be locked out, and then hop to the store the host frees. The stimulus gets there by committing two packets back to back before any reading starts. It then drains them one at a time, checking status and readiness between the two end-of-packet pulses. The clear is exercised in two situations. In the first, one store is committed and the other is half-loaded. In the second, the clear lands in the same cycle as a commit. Both cases are followed by a fresh packet whose bytes the scoreboard must see from offset zero.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int STATUS_W = 8;

  // Control-to-datapath strobes
  typedef struct packed {
    logic cpuBuf;   // store owned by the processor side
    logic hostBuf;  // store offered to the host side
    logic wrEn;     // write cpuWrData into cpuBuf
    logic rdEn;     // advance the read pointer of hostBuf
    logic freeEn;   // empty hostBuf after end of packet
    logic flush;    // empty both stores
  } bufStrobe_t;
endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic             cpuCommit,
  input  logic             clrWrite,
  input  logic             hostRdEn,
  input  logic             hostEop,
  input  logic             intAck,
  input  logic [CNT_W-1:0] cpuCnt,
  input  logic             rdLeft,
  output bufStrobe_t       strb,
  output logic             cpuWrReady,
  output logic             bufFull,
  output logic             hostPktReady,
  output logic             hostDataValid,
  output logic             dataStatus,
  output logic             clrBit,
  output logic             pktSentFlag
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [1:0] committedQ, committedN;
  logic       cpuSelQ, cpuSelN;
  logic       hostSelQ, hostSelN;
  logic       clrBitQ, flagQ;
  logic       commitOk, freeOk;

  always_comb begin
    cpuWrReady    = !committedQ[cpuSelQ] && (cpuCnt < CAP);
    bufFull       = committedQ[0] && committedQ[1];
    hostPktReady  = committedQ[hostSelQ];
    hostDataValid = hostPktReady && rdLeft;
    dataStatus    = committedQ[0] || committedQ[1];

    commitOk = cpuCommit && !committedQ[cpuSelQ] && !clrWrite;
    freeOk   = hostEop && committedQ[hostSelQ] && !clrWrite;

    committedN = committedQ;
    if (freeOk)   committedN[hostSelQ] = 1'b0;
    if (commitOk) committedN[cpuSelQ]  = 1'b1;

    hostSelN = freeOk ? !hostSelQ : hostSelQ;
    cpuSelN  = (committedN[cpuSelQ] && !committedN[!cpuSelQ]) ? !cpuSelQ : cpuSelQ;

    strb.cpuBuf  = cpuSelQ;
    strb.hostBuf = hostSelQ;
    strb.wrEn    = cpuWrEn && cpuWrReady && !clrWrite;
    strb.rdEn    = hostRdEn && hostDataValid && !clrWrite;
    strb.freeEn  = freeOk;
    strb.flush   = clrWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      committedQ <= '0;
      cpuSelQ    <= 1'b0;
      hostSelQ   <= 1'b0;
      clrBitQ    <= 1'b0;
      flagQ      <= 1'b0;
    end else begin
      clrBitQ <= clrWrite;
      if (freeOk)      flagQ <= 1'b1;
      else if (intAck) flagQ <= 1'b0;
      if (clrWrite) begin
        committedQ <= '0;
        cpuSelQ    <= 1'b0;
        hostSelQ   <= 1'b0;
      end else begin
        committedQ <= committedN;
        cpuSelQ    <= cpuSelN;
        hostSelQ   <= hostSelN;
      end
    end
  end

  assign clrBit      = clrBitQ;
  assign pktSentFlag = flagQ;
endmodule

// File: rtl/txbuf_data.sv
module txbuf_data
  import txbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cpuCnt,
  output logic [CNT_W-1:0]  hostLen,
  output logic              rdLeft,
  output logic [DATA_W-1:0] rdData
);
  logic [CNT_W-1:0]  cntArr [2];
  logic [CNT_W-1:0]  ptrArr [2];
  logic [DATA_W-1:0] outArr [2];

  for (genvar b = 0; b < 2; b++) begin : g_store
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cntQ, ptrQ;
    logic              wrHere, rdHere, freeHere;

    assign wrHere   = strb.wrEn   && (strb.cpuBuf  == 1'(b));
    assign rdHere   = strb.rdEn   && (strb.hostBuf == 1'(b));
    assign freeHere = strb.freeEn && (strb.hostBuf == 1'(b));

    always_ff @(posedge clk) begin
      if (wrHere) mem[cntQ[ADDR_W-1:0]] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN || strb.flush || freeHere) begin
        cntQ <= '0;
        ptrQ <= '0;
      end else begin
        if (wrHere) cntQ <= cntQ + 1'b1;
        if (rdHere) ptrQ <= ptrQ + 1'b1;
      end
    end

    assign cntArr[b] = cntQ;
    assign ptrArr[b] = ptrQ;
    assign outArr[b] = mem[ptrQ[ADDR_W-1:0]];
  end

  assign cpuCnt  = cntArr[strb.cpuBuf];
  assign hostLen = cntArr[strb.hostBuf];
  assign rdLeft  = ptrArr[strb.hostBuf] < cntArr[strb.hostBuf];
  assign rdData  = outArr[strb.hostBuf];
endmodule

// File: rtl/ep_tx_pingpong.sv
module ep_tx_pingpong
  import txbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuCommit,
  input  logic              clrWrite,
  input  logic              hostRdEn,
  input  logic              hostEop,
  input  logic              intAck,
  output logic              cpuWrReady,
  output logic              bufFull,
  output logic              hostPktReady,
  output logic              hostDataValid,
  output logic [DATA_W-1:0] hostRdData,
  output logic [CNT_W-1:0]  hostPktLen,
  output logic              dataStatus,
  output logic [7:0]        statusReg,
  output logic              clrBit,
  output logic              pktSentFlag
);
  bufStrobe_t       strb;
  logic [CNT_W-1:0] cpuCnt;
  logic             rdLeft;

  txbuf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuCommit(cpuCommit),
    .clrWrite(clrWrite), .hostRdEn(hostRdEn), .hostEop(hostEop), .intAck(intAck),
    .cpuCnt(cpuCnt), .rdLeft(rdLeft), .strb(strb), .cpuWrReady(cpuWrReady),
    .bufFull(bufFull), .hostPktReady(hostPktReady), .hostDataValid(hostDataValid),
    .dataStatus(dataStatus), .clrBit(clrBit), .pktSentFlag(pktSentFlag)
  );

  txbuf_data #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(cpuWrData),
    .cpuCnt(cpuCnt), .hostLen(hostPktLen), .rdLeft(rdLeft), .rdData(hostRdData)
  );

  assign statusReg = {{(STATUS_W-1){1'b0}}, dataStatus};
endmodule

// File: rtl/ep_tx_pingpong_chk.sv
module ep_tx_pingpong_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuCommit,
  input logic       clrWrite,
  input logic       hostEop,
  input logic       intAck,
  input logic       cpuWrReady,
  input logic       bufFull,
  input logic       hostPktReady,
  input logic       dataStatus,
  input logic [7:0] statusReg,
  input logic       clrBit,
  input logic       pktSentFlag
);
  p_status_layout_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusReg == {7'b0, dataStatus});

  p_commit_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuCommit && !bufFull && !clrWrite) |=> dataStatus);

  p_full_locks_r4: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !cpuWrReady);

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataStatus && !hostEop && !clrWrite) |=> dataStatus);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> (!bufFull && !hostPktReady));

  p_clr_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> clrBit);

  p_clr_only_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrBit |-> $past(clrWrite));

  p_flag_untouched_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !intAck && !hostEop) |=> $stable(pktSentFlag));

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && cpuCommit) |=> !dataStatus);
endmodule

bind ep_tx_pingpong ep_tx_pingpong_chk u_chk (.*);

// File: tb/test_ep_tx_pingpong.sv
module test_ep_tx_pingpong;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN = 1'b0;
  logic              cpuWrEn = 1'b0, cpuCommit = 1'b0, clrWrite = 1'b0;
  logic              hostRdEn = 1'b0, hostEop = 1'b0, intAck = 1'b0;
  logic [DATA_W-1:0] cpuWrData = '0;
  logic              cpuWrReady, bufFull, hostPktReady, hostDataValid;
  logic [DATA_W-1:0] hostRdData;
  logic [CNT_W-1:0]  hostPktLen;
  logic              dataStatus, clrBit, pktSentFlag;
  logic [7:0]        statusReg;

  ep_tx_pingpong #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ep_tx_pingpong (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .cpuCommit(cpuCommit), .clrWrite(clrWrite), .hostRdEn(hostRdEn),
    .hostEop(hostEop), .intAck(intAck), .cpuWrReady(cpuWrReady),
    .bufFull(bufFull), .hostPktReady(hostPktReady), .hostDataValid(hostDataValid),
    .hostRdData(hostRdData), .hostPktLen(hostPktLen), .dataStatus(dataStatus),
    .statusReg(statusReg), .clrBit(clrBit), .pktSentFlag(pktSentFlag)
  );

  int nRun = 0;
  int nFail = 0;
  logic [DATA_W-1:0] expQ[$];
  int lenQ[$];
  int pendLen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs are applied 2 ns after an edge and consumed at the next edge.
  task automatic tick();
    @(posedge clk);
    #2;
    cpuWrEn = 0; cpuCommit = 0; clrWrite = 0;
    hostRdEn = 0; hostEop = 0; intAck = 0;
  endtask

  task automatic wrByte(input logic [DATA_W-1:0] d, input bit accept);
    cpuWrEn = 1; cpuWrData = d;
    if (accept) begin
      expQ.push_back(d);
      pendLen++;
    end
    tick();
  endtask

  task automatic commitPkt();
    cpuCommit = 1;
    lenQ.push_back(pendLen);
    pendLen = 0;
    tick();
  endtask

  task automatic readPkt(input int n);
    for (int i = 0; i < n; i++) begin
      hostRdEn = 1;
      tick();
    end
    chk(hostPktLen == CNT_W'(lenQ[0]), "R5 packet length", int'(hostPktLen), lenQ[0]);
    chk(!hostDataValid, "R5 all bytes read", int'(hostDataValid), 0);
    void'(lenQ.pop_front());
    hostEop = 1;
    tick();
  endtask

  // Scoreboard monitor: compare each accepted host read with the queue head
  always @(negedge clk) begin
    if (rstN && hostRdEn && hostDataValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5 unexpected byte", int'(hostRdData), -1);
      end else begin
        chk(hostRdData == expQ[0], "R5 byte order", int'(hostRdData), int'(expQ[0]));
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1 reset state
    chk(!dataStatus && statusReg == 8'h00, "R1 status", int'(statusReg), 0);
    chk(!bufFull && cpuWrReady, "R1 ready", int'(cpuWrReady), 1);
    chk(!hostPktReady && !hostDataValid && !clrBit && !pktSentFlag, "R1 flags",
        int'({hostPktReady, hostDataValid, clrBit, pktSentFlag}), 0);

    // R2 writes alone leave status low, commit raises it
    wrByte(8'h11, 1); wrByte(8'h22, 1); wrByte(8'h33, 1);
    chk(!dataStatus, "R2 no status on write", int'(dataStatus), 0);
    commitPkt();
    chk(dataStatus && statusReg == 8'h01, "R2 status after commit", int'(statusReg), 1);
    chk(cpuWrReady, "R2 cpu moved to free store", int'(cpuWrReady), 1);

    // R4 second packet fills both stores
    wrByte(8'h44, 1); wrByte(8'h55, 1);
    commitPkt();
    chk(bufFull && !cpuWrReady, "R4 full", int'({bufFull, cpuWrReady}), 2);
    wrByte(8'hEE, 0);
    cpuCommit = 1; tick();
    chk(bufFull, "R4 commit ignored while full", int'(bufFull), 1);

    // R5/R6/R12 drain first store
    readPkt(3);
    chk(dataStatus, "R6 status held with one store left", int'(dataStatus), 1);
    chk(cpuWrReady && !bufFull, "R12 cpu takes freed store", int'(cpuWrReady), 1);
    chk(pktSentFlag, "R10 flag set on eop", int'(pktSentFlag), 1);
    chk(hostPktLen == 2, "R4 refused byte not stored", int'(hostPktLen), 2);
    readPkt(2);
    chk(!dataStatus && statusReg == 8'h00, "R6 status low when both empty", int'(statusReg), 0);
    intAck = 1; tick();
    chk(!pktSentFlag, "R10 ack clears flag", int'(pktSentFlag), 0);

    // R3 zero-length packet
    commitPkt();
    chk(dataStatus && hostPktReady, "R3 zlp sets status", int'({dataStatus, hostPktReady}), 3);
    chk(hostPktLen == 0 && !hostDataValid, "R3 zlp length", int'(hostPktLen), 0);
    readPkt(0);
    chk(!dataStatus, "R3 zlp freed", int'(dataStatus), 0);

    // R7 capacity
    for (int i = 0; i < DEPTH; i++) wrByte(DATA_W'(i + 8'h80), 1);
    chk(!cpuWrReady && !bufFull, "R7 store full", int'(cpuWrReady), 0);
    wrByte(8'hFF, 0);
    commitPkt();
    chk(hostPktLen == CNT_W'(DEPTH), "R7 length capped", int'(hostPktLen), DEPTH);
    readPkt(DEPTH);

    // R8/R9/R10 clear with committed and uncommitted data present
    wrByte(8'hA1, 1); wrByte(8'hA2, 1); wrByte(8'hA3, 1); wrByte(8'hA4, 1);
    commitPkt();
    wrByte(8'hB1, 1); wrByte(8'hB2, 1);
    clrWrite = 1; tick();
    expQ.delete(); lenQ.delete(); pendLen = 0;
    chk(!dataStatus && !bufFull && !hostPktReady, "R8 flushed",
        int'({dataStatus, bufFull, hostPktReady}), 0);
    chk(clrBit, "R9 clear bit reads 1", int'(clrBit), 1);
    chk(pktSentFlag, "R10 clear keeps flag", int'(pktSentFlag), 1);
    tick();
    chk(!clrBit, "R9 clear bit self-clears", int'(clrBit), 0);
    wrByte(8'h5A, 1);
    commitPkt();
    chk(hostPktLen == 1, "R8 fresh packet length", int'(hostPktLen), 1);
    readPkt(1);

    // R11 clear and commit together
    wrByte(8'h66, 1);
    cpuCommit = 1; clrWrite = 1; tick();
    expQ.delete(); pendLen = 0;
    chk(!dataStatus && !hostPktReady, "R11 clear beats commit", int'(dataStatus), 0);
    chk(cpuWrReady, "R11 store writable again", int'(cpuWrReady), 1);

    tick();
    chk(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule